// File: doc/BRIEF.md
# Chained Bus Authentication Checker

Each member of a processor group owns one copy of this checker. Every data transfer the group puts on the shared bus is folded into a running authentication code. The plaintext block is XORed with the current code and with the originator's processor ID. The result then passes through a fixed-latency keyed mixing pipeline, which stands in for the real cipher. Because the code is chained over the whole broadcast history, a member that missed a transfer, saw transfers in a different order, or saw a transfer with a forged origin ends up holding a different code from the other members.

The codes start from an authentication IV that must differ from the encryption initial mask. One code chain is kept per encryption mask, and the tag that is compared covers all of them. A transfer counter opens an authentication round once a programmed number of transfers has been absorbed. The member that drives the tag for a round rotates round-robin. All other members compare the tag seen on the bus with their own. A mismatch, or an authentication message that arrives out of turn, raises a sticky alarm that halts the group.

Top module: `bus_mac_auth`

## Requirements
- R1: A one-cycle `start` clears all state. Chain c is set to `cfg_iv ^ c`, the counter and initiator go to 0, no round is open, and `cfg_interval` is captured. `my_tag` is the top TAG_W bits of the modulo-2^BLK_W sum of all chain codes.
- R2: A transfer on chain c replaces that chain's code with mix^MIX_LAT(code ^ block ^ (pid << (BLK_W-PID_W))). Here mix(x) = rotl(x,5) ^ (x + KEY). The new value is visible MIX_LAT+1 cycles after the transfer is sampled. Transfers are spaced at least MIX_LAT+1 cycles apart.
- R3: A transfer changes only the code of the chain it names. `my_tag` does not change while no transfer is being mixed.
- R4: The round counter counts transfers. When the count reaches the captured interval, a round opens and the counter returns to 0. An interval of 1 opens a round after every transfer, and an interval of 0 means 256.
- R5: An open round shows `check_ready` only after every update still in the mixing pipeline has landed.
- R6: The initiator starts at member 0 and advances by one, modulo MEMBERS, each time a round closes. `tag_drive` is high while `check_ready` is high and `initiator` equals `self_id`.
- R7: When a round closes on an authentication message and this member is not the initiator, a received tag that differs from `my_tag` sets `alarm`, and an equal tag leaves it clear.
- R8: The initiator does not compare its own message seen back on the bus.
- R9: Only command code 2'b00 on `auth_cmd` marks an authentication message. Other codes have no effect on the round or on the alarm.
- R10: An authentication message that arrives while the round's update is still being mixed is held. It is compared as soon as the pipeline drains.
- R11: An authentication message that arrives while no round is open sets `alarm`.
- R12: `start` with `cfg_iv` equal to `cfg_enc_mask` sets `alarm`.
- R13: `alarm` stays set, through later rounds that match, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Group start: load IV, interval, clear state |
| cfg_iv | input | BLK_W | Authentication IV |
| cfg_enc_mask | input | BLK_W | Encryption initial mask, compared against the IV |
| cfg_interval | input | 8 | Transfers per authentication round (0 = 256) |
| self_id | input | PID_W | This member's index in the group |
| xfer_valid | input | 1 | A group data transfer is on the bus |
| xfer_chain | input | CH_W | Mask chain the transfer belongs to |
| xfer_pid | input | PID_W | Originating processor |
| xfer_block | input | BLK_W | Plaintext block of the transfer |
| auth_valid | input | 1 | A bus message is present |
| auth_cmd | input | 2 | Command code of that message |
| auth_tag | input | TAG_W | Tag carried by the message |
| my_tag | output | TAG_W | Local truncated tag |
| check_ready | output | 1 | Round open and pipeline drained |
| tag_drive | output | 1 | This member must drive `my_tag` now |
| initiator | output | PID_W | Member that drives the current round |
| alarm | output | 1 | Sticky authentication failure |

## Verification
A table of transfers mixes both chains and four originators, and the local tag is compared with an independent model after every step. This separates chain selection, originator folding and round counting. Rounds are run with a matching tag, with a corrupted tag at a non-initiator, and with a corrupted echo at the initiator, which separates the compare from the initiator exemption. Directed cases send the tag while the update is still in flight, send a non-authentication command code, send an authentication message while no round is open, start with a colliding IV, and use the wrap interval of 256.

// File: rtl/bmac_pkg.sv
package bmac_pkg;

   typedef enum logic [1:0] {
      BCMD_AUTH = 2'b00,
      BCMD_READ = 2'b01,
      BCMD_RDEX = 2'b10,
      BCMD_WBK  = 2'b11
   } bus_cmd_e;

   localparam int unsigned INTV_W = 8;

   function automatic int unsigned ptr_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/bmac_mixer.sv
module bmac_mixer #(
   parameter int unsigned W    = 32,
   parameter int unsigned CH_W = 1,
   parameter int unsigned LAT  = 3,
   parameter logic [W-1:0] KEY = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic            in_v,
   input  logic [W-1:0]    in_x,
   input  logic [CH_W-1:0] in_ch,
   output logic            out_v,
   output logic [W-1:0]    out_y,
   output logic [CH_W-1:0] out_ch,
   output logic            busy
);

   function automatic logic [W-1:0] mix_rnd(input logic [W-1:0] x);
      return {x[W-6:0], x[W-1:W-5]} ^ (x + KEY);
   endfunction

   logic [LAT-1:0]  st_v;
   logic [W-1:0]    st_d [LAT];
   logic [CH_W-1:0] st_c [LAT];

   for (genvar s = 0; s < LAT; s++) begin : g_stage
      logic            src_v;
      logic [W-1:0]    src_d;
      logic [CH_W-1:0] src_c;
      if (s == 0) begin : g_head
         assign src_v = in_v;
         assign src_d = in_x;
         assign src_c = in_ch;
      end else begin : g_body
         assign src_v = st_v[s-1];
         assign src_d = st_d[s-1];
         assign src_c = st_c[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_v[s] <= 1'b0;
            st_d[s] <= '0;
            st_c[s] <= '0;
         end else begin
            st_v[s] <= src_v & ~flush;
            if (src_v) begin
               st_d[s] <= mix_rnd(src_d);
               st_c[s] <= src_c;
            end
         end
      end
   end

   assign out_v  = st_v[LAT-1] & ~flush;
   assign out_y  = st_d[LAT-1];
   assign out_ch = st_c[LAT-1];
   assign busy   = |st_v;

endmodule

// File: rtl/bmac_chain_bank.sv
module bmac_chain_bank #(
   parameter int unsigned W      = 32,
   parameter int unsigned NCHAIN = 2,
   parameter int unsigned CH_W   = 1,
   parameter int unsigned TAG_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic [W-1:0]     iv,
   input  logic             upd_v,
   input  logic [CH_W-1:0]  upd_ch,
   input  logic [W-1:0]     upd_y,
   input  logic [CH_W-1:0]  sel_ch,
   output logic [W-1:0]     sel_mac,
   output logic [TAG_W-1:0] tag
);

   logic [W-1:0] mac [NCHAIN];

   for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mac[c] <= '0;
         else if (init)
            mac[c] <= iv ^ W'(c);
         else if (upd_v && upd_ch == CH_W'(c))
            mac[c] <= upd_y;
      end
   end

   logic [W-1:0] acc;
   always_comb begin
      acc     = '0;
      sel_mac = '0;
      for (int c = 0; c < NCHAIN; c++) begin
         acc = acc + mac[c];
         if (sel_ch == CH_W'(c))
            sel_mac = mac[c];
      end
   end

   assign tag = acc[W-1 -: TAG_W];

endmodule

// File: rtl/bmac_round_ctl.sv
module bmac_round_ctl #(
   parameter int unsigned MEMBERS = 4,
   parameter int unsigned PID_W   = 2,
   parameter int unsigned TAG_W   = 16,
   parameter int unsigned INTV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [INTV_W-1:0] interval,
   input  logic              iv_clash,
   input  logic              xfer_v,
   input  logic              busy,
   input  logic              auth_v,
   input  logic [TAG_W-1:0]  auth_tag,
   input  logic [TAG_W-1:0]  my_tag,
   input  logic [PID_W-1:0]  self_id,
   output logic              pend,
   output logic              ready,
   output logic [PID_W-1:0]  initiator,
   output logic              alarm
);

   logic [INTV_W-1:0] intv_q, cnt_q;
   logic              hold_v;
   logic [TAG_W-1:0]  hold_tag;

   wire [INTV_W-1:0] cnt_inc  = cnt_q + 1'b1;
   wire              hit      = xfer_v && (cnt_inc == intv_q);
   wire              do_cmp   = ready && (hold_v || auth_v);
   wire [TAG_W-1:0]  cmp_tag  = hold_v ? hold_tag : auth_tag;
   wire              foreign  = (initiator != self_id);
   wire              mismatch = do_cmp && foreign && (cmp_tag != my_tag);
   wire              stray    = auth_v && !pend;
   wire              park     = auth_v && pend && busy && !hold_v;
   wire [PID_W-1:0]  init_nx  = (initiator == PID_W'(MEMBERS-1)) ? '0 : initiator + 1'b1;

   assign ready = pend && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         intv_q    <= '0;
         cnt_q     <= '0;
         pend      <= 1'b0;
         hold_v    <= 1'b0;
         hold_tag  <= '0;
         initiator <= '0;
         alarm     <= 1'b0;
      end else if (start) begin
         intv_q    <= interval;
         cnt_q     <= '0;
         pend      <= 1'b0;
         hold_v    <= 1'b0;
         hold_tag  <= '0;
         initiator <= '0;
         alarm     <= iv_clash;
      end else begin
         if (xfer_v)
            cnt_q <= hit ? '0 : cnt_inc;
         if (do_cmp) begin
            pend      <= 1'b0;
            hold_v    <= 1'b0;
            initiator <= init_nx;
         end else begin
            if (hit)
               pend <= 1'b1;
            if (park) begin
               hold_v   <= 1'b1;
               hold_tag <= auth_tag;
            end
         end
         if (mismatch || stray)
            alarm <= 1'b1;
      end
   end

endmodule

// File: rtl/bus_mac_auth.sv
module bus_mac_auth
   import bmac_pkg::*;
#(
   parameter int unsigned  BLK_W   = 32,
   parameter int unsigned  PID_W   = 2,
   parameter int unsigned  MEMBERS = 4,
   parameter int unsigned  TAG_W   = 16,
   parameter int unsigned  MIX_LAT = 3,
   parameter int unsigned  NCHAIN  = 2,
   parameter logic [BLK_W-1:0] KEY = BLK_W'(32'h9E37_79B9),
   localparam int unsigned CH_W    = ptr_w(NCHAIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BLK_W-1:0]  cfg_iv,
   input  logic [BLK_W-1:0]  cfg_enc_mask,
   input  logic [INTV_W-1:0] cfg_interval,
   input  logic [PID_W-1:0]  self_id,
   input  logic              xfer_valid,
   input  logic [CH_W-1:0]   xfer_chain,
   input  logic [PID_W-1:0]  xfer_pid,
   input  logic [BLK_W-1:0]  xfer_block,
   input  logic              auth_valid,
   input  logic [1:0]        auth_cmd,
   input  logic [TAG_W-1:0]  auth_tag,
   output logic [TAG_W-1:0]  my_tag,
   output logic              check_ready,
   output logic              tag_drive,
   output logic [PID_W-1:0]  initiator,
   output logic              alarm
);

   if (BLK_W < 8)             begin : g_bad_w   $error("BLK_W must be at least 8"); end
   if (TAG_W > BLK_W)         begin : g_bad_t   $error("TAG_W exceeds BLK_W"); end
   if (PID_W >= BLK_W)        begin : g_bad_p   $error("PID_W too wide"); end
   if (MEMBERS > (1 << PID_W)) begin : g_bad_m  $error("MEMBERS exceeds PID space"); end
   if (MIX_LAT < 1)           begin : g_bad_l   $error("MIX_LAT must be at least 1"); end
   if (NCHAIN < 1)            begin : g_bad_c   $error("NCHAIN must be at least 1"); end

   logic [BLK_W-1:0] sel_mac, mix_in, mix_y;
   logic [CH_W-1:0]  mix_ch;
   logic             mix_v, mix_busy, pend;

   wire auth_hit = auth_valid && (auth_cmd == BCMD_AUTH);

   assign mix_in = sel_mac ^ xfer_block ^ {xfer_pid, {(BLK_W-PID_W){1'b0}}};

   bmac_mixer #(.W(BLK_W), .CH_W(CH_W), .LAT(MIX_LAT), .KEY(KEY)) u_mix (
      .clk(clk), .rst_n(rst_n), .flush(start),
      .in_v(xfer_valid && !start), .in_x(mix_in), .in_ch(xfer_chain),
      .out_v(mix_v), .out_y(mix_y), .out_ch(mix_ch), .busy(mix_busy)
   );

   bmac_chain_bank #(.W(BLK_W), .NCHAIN(NCHAIN), .CH_W(CH_W), .TAG_W(TAG_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .init(start), .iv(cfg_iv),
      .upd_v(mix_v), .upd_ch(mix_ch), .upd_y(mix_y),
      .sel_ch(xfer_chain), .sel_mac(sel_mac), .tag(my_tag)
   );

   bmac_round_ctl #(.MEMBERS(MEMBERS), .PID_W(PID_W), .TAG_W(TAG_W), .INTV_W(INTV_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .start(start), .interval(cfg_interval),
      .iv_clash(cfg_iv == cfg_enc_mask), .xfer_v(xfer_valid && !start),
      .busy(mix_busy), .auth_v(auth_hit && !start), .auth_tag(auth_tag),
      .my_tag(my_tag), .self_id(self_id), .pend(pend), .ready(check_ready),
      .initiator(initiator), .alarm(alarm)
   );

   assign tag_drive = check_ready && (initiator == self_id);

endmodule

// File: rtl/bus_mac_auth_chk.sv
module bus_mac_auth_chk #(
   parameter int unsigned PID_W   = 2,
   parameter int unsigned TAG_W   = 16,
   parameter int unsigned MEMBERS = 4,
   parameter int unsigned MIX_LAT = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             iv_ok,
   input logic             xfer_valid,
   input logic             auth_valid,
   input logic [1:0]       auth_cmd,
   input logic [TAG_W-1:0] auth_tag,
   input logic [TAG_W-1:0] my_tag,
   input logic [PID_W-1:0] self_id,
   input logic             check_ready,
   input logic             pend,
   input logic             mix_busy,
   input logic [PID_W-1:0] initiator,
   input logic             alarm
);

   localparam int unsigned GAP_W = $clog2(MIX_LAT + 2) + 1;
   logic [GAP_W-1:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap <= GAP_W'(MIX_LAT);
      else if (xfer_valid)
         gap <= '0;
      else if (gap < GAP_W'(MIX_LAT))
         gap <= gap + 1'b1;
   end

   wire closing = check_ready && auth_valid && auth_cmd == 2'b00 && !start;

   AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      start && iv_ok |=> !alarm && !pend && initiator == '0); // R1
   AST_XFER_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && !start |-> gap >= GAP_W'(MIX_LAT)); // R2
   AST_TAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !mix_busy && !xfer_valid && !start |=> $stable(my_tag)); // R3
   AST_NO_XFER_IN_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && !start |-> !pend); // R5
   AST_INIT_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
      closing |=> initiator == (($past(initiator) == PID_W'(MEMBERS-1)) ? '0 : $past(initiator) + 1'b1)); // R6
   AST_MISMATCH_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
      closing && initiator != self_id && auth_tag != my_tag |=> alarm); // R7
   AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      alarm && !start |=> alarm); // R13

endmodule

bind bus_mac_auth bus_mac_auth_chk #(
   .PID_W(PID_W), .TAG_W(TAG_W), .MEMBERS(MEMBERS), .MIX_LAT(MIX_LAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .iv_ok(cfg_iv != cfg_enc_mask),
   .xfer_valid(xfer_valid), .auth_valid(auth_valid), .auth_cmd(auth_cmd),
   .auth_tag(auth_tag), .my_tag(my_tag), .self_id(self_id),
   .check_ready(check_ready), .pend(pend), .mix_busy(mix_busy),
   .initiator(initiator), .alarm(alarm)
);

// File: tb/bus_mac_auth_bench.sv
module bus_mac_auth_bench;

   localparam int unsigned BLK_W = 32, PID_W = 2, TAG_W = 16, LAT = 3, NCH = 2;
   localparam logic [31:0] KEY = 32'h9E37_79B9;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [31:0] cfg_iv = '0, cfg_enc_mask = '0, xfer_block = '0;
   logic [7:0]  cfg_interval = '0;
   logic [1:0]  self_id = 2'd1, xfer_pid = '0, auth_cmd = '0, initiator;
   logic        xfer_valid = 1'b0, xfer_chain = 1'b0, auth_valid = 1'b0;
   logic [15:0] auth_tag = '0, my_tag;
   logic        check_ready, tag_drive, alarm;

   always #5 clk = ~clk;

   bus_mac_auth u_bus_mac_auth (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_iv(cfg_iv),
      .cfg_enc_mask(cfg_enc_mask), .cfg_interval(cfg_interval), .self_id(self_id),
      .xfer_valid(xfer_valid), .xfer_chain(xfer_chain), .xfer_pid(xfer_pid),
      .xfer_block(xfer_block), .auth_valid(auth_valid), .auth_cmd(auth_cmd),
      .auth_tag(auth_tag), .my_tag(my_tag), .check_ready(check_ready),
      .tag_drive(tag_drive), .initiator(initiator), .alarm(alarm)
   );

   int n_chk = 0, n_bad = 0;
   logic [31:0] mac_m [NCH];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mix3(input logic [31:0] x);
      logic [31:0] y = x;
      for (int r = 0; r < LAT; r++) y = {y[26:0], y[31:27]} ^ (y + KEY);
      return y;
   endfunction

   function automatic logic [15:0] exp_tag();
      logic [31:0] s = mac_m[0] + mac_m[1];
      return s[31:16];
   endfunction

   task automatic do_start(input logic [31:0] iv, input logic [31:0] msk, input logic [7:0] iv_n);
      @(negedge clk);
      start = 1'b1; cfg_iv = iv; cfg_enc_mask = msk; cfg_interval = iv_n;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < NCH; c++) mac_m[c] = iv ^ 32'(c);
   endtask

   // drives one transfer; if settle, returns MIX_LAT+1 cycles after capture
   task automatic do_xfer(input logic ch, input logic [1:0] pid, input logic [31:0] blk, input bit settle);
      @(negedge clk);
      xfer_valid = 1'b1; xfer_chain = ch; xfer_pid = pid; xfer_block = blk;
      mac_m[ch] = mix3(mac_m[ch] ^ blk ^ {pid, 30'd0});
      @(negedge clk);
      xfer_valid = 1'b0;
      if (settle) repeat (LAT) @(negedge clk);
   endtask

   task automatic do_auth(input logic [1:0] cmd, input logic [15:0] tg);
      @(negedge clk);
      auth_valid = 1'b1; auth_cmd = cmd; auth_tag = tg;
      @(negedge clk);
      auth_valid = 1'b0;
   endtask

   // transfer vectors: {chain, pid, block}
   localparam logic [34:0] VEC [8] = '{
      {1'b0, 2'd0, 32'h0000_0001}, {1'b1, 2'd2, 32'hDEAD_BEEF},
      {1'b0, 2'd3, 32'hFFFF_FFFF}, {1'b0, 2'd1, 32'h0000_0000},
      {1'b1, 2'd1, 32'h8000_0000}, {1'b1, 2'd0, 32'h1234_5678},
      {1'b0, 2'd2, 32'hA5A5_5A5A}, {1'b1, 2'd3, 32'h0F0F_0F0F}};

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [1:0] exp_init;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset alarm", 32'(alarm), 0);

      do_start(32'h1234_5678, 32'hAAAA_AAAA, 8'd4);
      chk("R1 start alarm", 32'(alarm), 0);
      chk("R1 start ready", 32'(check_ready), 0);
      chk("R1 start initiator", 32'(initiator), 0);
      chk("R1 start tag", 32'(my_tag), 32'(exp_tag()));

      exp_init = 2'd0;
      for (int i = 0; i < 8; i++) begin
         do_xfer(VEC[i][34], VEC[i][33:32], VEC[i][31:0], 1'b1);
         chk("R2 R3 tag after transfer", 32'(my_tag), 32'(exp_tag()));
         if ((i % 4) == 3) begin
            chk("R4 round open", 32'(check_ready), 1);
            chk("R6 initiator", 32'(initiator), 32'(exp_init));
            chk("R6 drive", 32'(tag_drive), 32'(exp_init == self_id));
            if (exp_init == self_id) do_auth(2'b00, ~exp_tag());   // R8 echo
            else                     do_auth(2'b00, exp_tag());    // R7 match
            chk("R7 R8 no alarm", 32'(alarm), 0);
            chk("R4 round closed", 32'(check_ready), 0);
            exp_init = exp_init + 2'd1;
         end else begin
            chk("R4 no round yet", 32'(check_ready), 0);
         end
      end
      chk("R6 rotated", 32'(initiator), 2);

      // R5 R10: tag sent while the update is still mixing
      do_start(32'h0BAD_F00D, 32'h1111_1111, 8'd1);
      do_xfer(1'b1, 2'd3, 32'hCAFE_0001, 1'b0);
      chk("R5 not ready while mixing", 32'(check_ready), 0);
      auth_valid = 1'b1; auth_cmd = 2'b00; auth_tag = exp_tag();
      @(negedge clk);
      auth_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 held compare alarm", 32'(alarm), 0);
      chk("R10 held compare closed", 32'(check_ready), 0);
      chk("R6 R10 initiator advanced", 32'(initiator), 1);

      // R9: non-authentication command during an open round
      do_xfer(1'b0, 2'd2, 32'h5555_0000, 1'b1);
      chk("R5 ready after drain", 32'(check_ready), 1);
      do_auth(2'b01, 16'hBEEF);
      chk("R9 other cmd keeps round", 32'(check_ready), 1);
      chk("R9 other cmd no alarm", 32'(alarm), 0);
      chk("R6 self drives", 32'(tag_drive), 1);
      do_auth(2'b00, exp_tag());

      // R7 mismatch, then R13 sticky
      do_xfer(1'b0, 2'd0, 32'h7777_7777, 1'b1);
      chk("R6 initiator two", 32'(initiator), 2);
      do_auth(2'b00, ~exp_tag());
      chk("R7 mismatch alarm", 32'(alarm), 1);
      do_xfer(1'b1, 2'd1, 32'h0000_00FF, 1'b1);
      do_auth(2'b00, exp_tag());
      chk("R13 alarm sticky", 32'(alarm), 1);
      chk("R6 wrap to zero", 32'(initiator), 0);

      // R1 restart clears; R11 stray message
      do_start(32'hFEDC_BA98, 32'h0, 8'd3);
      chk("R1 restart alarm", 32'(alarm), 0);
      chk("R1 restart tag", 32'(my_tag), 32'(exp_tag()));
      do_auth(2'b00, exp_tag());
      chk("R11 stray auth alarm", 32'(alarm), 1);

      // R12 IV clash
      do_start(32'h4242_4242, 32'h4242_4242, 8'd1);
      chk("R12 iv clash alarm", 32'(alarm), 1);

      // R4 interval 0 means 256
      do_start(32'h0101_0101, 32'h0, 8'd0);
      for (int k = 0; k < 255; k++)
         do_xfer(1'(k), 2'(k), 32'(k * 32'h0101_0001), 1'b1);
      chk("R4 255 transfers no round", 32'(check_ready), 0);
      do_xfer(1'b1, 2'd3, 32'h0000_0100, 1'b1);
      chk("R4 256th opens round", 32'(check_ready), 1);
      chk("R2 long chain tag", 32'(my_tag), 32'(exp_tag()));
      do_auth(2'b00, exp_tag());
      chk("R7 long chain match", 32'(alarm), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule